// File: doc/BRIEF.md
# Receive/Transmit DMA Burst Arbiter

This block decides which of two DMA engines, a receive engine and a transmit engine, owns the host bus next. It also sizes the granted transaction as a burst of bus beats. Each engine raises a request level together with a two-bit request kind. The kind is a descriptor fetch, a descriptor close, or a buffer data move. The arbiter picks a winner while it is idle and latches the grant and the burst size. It holds that grant until the last beat of the burst has been acknowledged.

Two arbitration policies are selectable by a mode input. In round-robin mode the two engines have equal standing. In receive-first mode receive wins a tie, unless a transmission is in progress. While a transmission is in progress the two engines strictly interleave, so neither side can take two bursts in a row while the other waits.

Descriptor bursts move one 32-bit field, so their length follows the bus width. Data bursts take their length from a six-bit programmable code. Code zero means the burst has no fixed length: it stops on the beat where the relevant FIFO reports full (transmit) or empty (receive).

Top module: `dma_burst_arbiter`

## Requirements
- R1: While reset is active and on the first cycle after it, both grants and `xfer_done` are low.
- R2: With `rr_mode`=1, the winner of a tie is the engine that did not win the previous grant. The first tie after reset goes to receive.
- R3: With `rr_mode`=0 and `tx_active`=0, receive wins every tie.
- R4: With `rr_mode`=0 and `tx_active`=1, the winner of a tie is the engine that did not win the previous grant. No engine is granted twice in a row while the other has a request pending.
- R5: A lone requester is granted, with the grant visible one cycle after the idle cycle in which its request was seen.
- R6: Request kinds 2'b00 (descriptor fetch) and 2'b01 (descriptor close) give a burst of 1 beat at `DATA_W`=32, 2 beats at 16 and 4 beats at 8. The burst code is ignored for these kinds.
- R7: Request kinds 2'b10 and 2'b11 (data move) give a burst whose length equals the burst code when the code is 1, 2, 4, 8, 16 or 32.
- R8: A data burst with code 0 shows `burst_beats`=0 and `burst_unbounded`=1. It ends on the acknowledged beat where the stop flag is high: `rx_fifo_empty` for a receive grant, `tx_fifo_full` for a transmit grant.
- R9: Any other data code (3, 5-7, 9-15, 17-31, 33-63) gives a 32-beat burst.
- R10: The grant and the burst size stay unchanged until the burst completes, including cycles with `beat_ack` low. `xfer_done` is high only in the cycle of the final acknowledged beat.
- R11: The cycle after `xfer_done` carries no grant. The next arbitration decision is taken in that cycle.
- R12: `gnt_rx` and `gnt_tx` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | 1 | Receive engine request level |
| rx_kind | input | 2 | Receive request kind |
| tx_req | input | 1 | Transmit engine request level |
| tx_kind | input | 2 | Transmit request kind |
| rr_mode | input | 1 | 1 = round-robin, 0 = receive-first |
| tx_active | input | 1 | A frame transmission is in progress |
| burst_code | input | 6 | Programmable data burst length |
| rx_fifo_empty | input | 1 | Receive FIFO empty (stop flag for receive) |
| tx_fifo_full | input | 1 | Transmit FIFO full (stop flag for transmit) |
| beat_ack | input | 1 | One bus beat of the granted burst completed |
| gnt_rx | output | 1 | Bus granted to receive engine |
| gnt_tx | output | 1 | Bus granted to transmit engine |
| burst_beats | output | 6 | Beats in the granted burst (0 when unbounded) |
| burst_unbounded | output | 1 | Granted burst ends on the FIFO stop flag |
| xfer_done | output | 1 | Final beat of the granted burst |

## Verification
The bench drives back-to-back ties in each policy and keeps the winner's request high, so that it competes again at once. An arbiter without alternation would then hand the same engine two bursts in a row. Unbounded bursts assert the stop flag only on the final beat. A design that counted down, or that watched the wrong FIFO flag, would end early or never. Illegal burst codes, stalled beats within a burst, and narrow-bus descriptor sizing on separate 16-bit and 8-bit instances are all probed. A design that sized descriptors from the burst code, or that dropped the grant during a stall, would show the wrong length or a broken grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    REQ_DESC_FETCH = 2'b00,
    REQ_DESC_CLOSE = 2'b01,
    REQ_DATA       = 2'b10,
    REQ_DATA_ALT   = 2'b11
  } req_kind_e;

  // Beats needed to move one 32-bit descriptor field over a bus of width w.
  function automatic logic [5:0] desc_beats(input int unsigned w);
    if (w >= 32)      return 6'd1;
    else if (w >= 16) return 6'd2;
    else              return 6'd4;
  endfunction

  // Data burst length from the programmable code; 0 stays 0 (unbounded).
  function automatic logic [5:0] data_beats(input logic [5:0] code);
    case (code)
      6'd0, 6'd1, 6'd2, 6'd4, 6'd8, 6'd16, 6'd32: return code;
      default:                                     return 6'd32;
    endcase
  endfunction

  function automatic logic is_desc(input logic [1:0] kind);
    return (kind == REQ_DESC_FETCH) || (kind == REQ_DESC_CLOSE);
  endfunction

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_req,
  input  logic tx_req,
  input  logic rr_mode,
  input  logic tx_active,
  input  logic last_rx,
  input  logic enable,
  output logic pick_rx,
  output logic pick_tx
);

  logic tie;
  logic alternate;

  assign tie       = rx_req && tx_req;
  // Round-robin mode, or receive-first mode with a transmission in progress
  assign alternate = rr_mode || tx_active;

  always_comb begin
    pick_rx = 1'b0;
    pick_tx = 1'b0;
    if (enable) begin
      if (tie) begin
        if (alternate) begin
          pick_rx = !last_rx;
          pick_tx = last_rx;
        end else begin
          pick_rx = 1'b1;
        end
      end else begin
        pick_rx = rx_req;
        pick_tx = tx_req;
      end
    end
  end

  // R12
  pick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pick_rx, pick_tx}));

  // R5
  pick_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_rx -> rx_req) && (pick_tx -> tx_req));

endmodule

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer
  import dma_arb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEAT_W = 6
) (
  input  logic [1:0]        kind,
  input  logic [5:0]        code,
  output logic [BEAT_W-1:0] beats,
  output logic              unbounded
);

  localparam logic [5:0] DESC_LEN = desc_beats(DATA_W);

  logic       desc_kind;
  logic [5:0] data_len;

  assign desc_kind = is_desc(kind);
  assign data_len  = data_beats(code);

  always_comb begin
    if (desc_kind) begin
      beats     = BEAT_W'(DESC_LEN);
      unbounded = 1'b0;
    end else begin
      beats     = BEAT_W'(data_len);
      unbounded = (data_len == 6'd0);
    end
  end

endmodule

// File: rtl/dma_beat_counter.sv
module dma_beat_counter #(
  parameter int BEAT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BEAT_W-1:0] load_beats,
  input  logic              load_unb,
  input  logic              active,
  input  logic              beat_ack,
  input  logic              stop_flag,
  output logic              last_beat
);

  logic [BEAT_W-1:0] remain;
  logic              unb_q;
  logic              beat_taken;

  assign beat_taken = active && beat_ack;
  assign last_beat  = beat_taken && (unb_q ? stop_flag : (remain == BEAT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      unb_q  <= 1'b0;
    end else if (load) begin
      remain <= load_beats;
      unb_q  <= load_unb;
    end else if (beat_taken && !unb_q) begin
      remain <= remain - BEAT_W'(1);
    end
  end

  // R10
  remain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !unb_q) |-> (remain != '0));

  // R10
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && active));

endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
  import dma_arb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_req,
  input  logic [1:0] rx_kind,
  input  logic       tx_req,
  input  logic [1:0] tx_kind,
  input  logic       rr_mode,
  input  logic       tx_active,
  input  logic [5:0] burst_code,
  input  logic       rx_fifo_empty,
  input  logic       tx_fifo_full,
  input  logic       beat_ack,
  output logic       gnt_rx,
  output logic       gnt_tx,
  output logic [5:0] burst_beats,
  output logic       burst_unbounded,
  output logic       xfer_done
);

  localparam int BEAT_W = $clog2(MAX_BURST) + 1;

  logic              busy;
  logic              own_rx;
  logic              last_rx;
  logic [BEAT_W-1:0] beats_q;
  logic              unb_q;

  logic              pick_rx, pick_tx;
  logic              load;
  logic [1:0]        win_kind;
  logic [BEAT_W-1:0] size_beats;
  logic              size_unb;
  logic              stop_flag;
  logic              last_beat;

  dma_arb_pick u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_req    (rx_req),
    .tx_req    (tx_req),
    .rr_mode   (rr_mode),
    .tx_active (tx_active),
    .last_rx   (last_rx),
    .enable    (!busy),
    .pick_rx   (pick_rx),
    .pick_tx   (pick_tx)
  );

  assign win_kind = pick_rx ? rx_kind : tx_kind;
  assign load     = pick_rx || pick_tx;

  dma_burst_sizer #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_size (
    .kind      (win_kind),
    .code      (burst_code),
    .beats     (size_beats),
    .unbounded (size_unb)
  );

  assign stop_flag = own_rx ? rx_fifo_empty : tx_fifo_full;

  dma_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_beats (size_beats),
    .load_unb   (size_unb),
    .active     (busy),
    .beat_ack   (beat_ack),
    .stop_flag  (stop_flag),
    .last_beat  (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      own_rx  <= 1'b0;
      last_rx <= 1'b0;
      beats_q <= '0;
      unb_q   <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        busy    <= 1'b1;
        own_rx  <= pick_rx;
        last_rx <= pick_rx;
        beats_q <= size_beats;
        unb_q   <= size_unb;
      end
    end else if (last_beat) begin
      busy <= 1'b0;
    end
  end

  assign gnt_rx          = busy && own_rx;
  assign gnt_tx          = busy && !own_rx;
  assign burst_beats     = 6'(beats_q);
  assign burst_unbounded = unb_q;
  assign xfer_done       = last_beat;

  // R12
  gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_rx, gnt_tx}));

  // R10
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_rx || gnt_tx) && !xfer_done) |=>
      ($stable(gnt_rx) && $stable(gnt_tx) && $stable(burst_beats) && $stable(burst_unbounded)));

  // R11
  gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (!gnt_rx && !gnt_tx));

  // R10
  done_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ((gnt_rx || gnt_tx) && beat_ack));

  // R5
  rx_grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_rx) |-> $past(rx_req));

  // R5
  tx_grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_tx) |-> $past(tx_req));

endmodule

// File: tb/sim_dma_burst_arbiter.sv
module sim_dma_burst_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_req = 0, tx_req = 0;
  logic [1:0] rx_kind = 0, tx_kind = 0;
  logic       rr_mode = 0, tx_active = 0;
  logic [5:0] burst_code = 0;
  logic       rx_fifo_empty = 0, tx_fifo_full = 0, beat_ack = 0;
  logic       gnt_rx, gnt_tx, burst_unbounded, xfer_done;
  logic [5:0] burst_beats;

  logic       w_req = 0, w_ack = 0;
  logic       g1_rx, g1_tx, g1_unb, g1_done, g2_rx, g2_tx, g2_unb, g2_done;
  logic [5:0] g1_beats, g2_beats;

  int nchk = 0;
  int nerr = 0;
  bit model_last_rx = 0;
  bit prev_gnt = 0;

  typedef struct {
    bit    rx;
    int    beats;
    bit    unb;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  dma_burst_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .rx_kind(rx_kind),
    .tx_req(tx_req), .tx_kind(tx_kind), .rr_mode(rr_mode), .tx_active(tx_active),
    .burst_code(burst_code), .rx_fifo_empty(rx_fifo_empty), .tx_fifo_full(tx_fifo_full),
    .beat_ack(beat_ack), .gnt_rx(gnt_rx), .gnt_tx(gnt_tx), .burst_beats(burst_beats),
    .burst_unbounded(burst_unbounded), .xfer_done(xfer_done));

  dma_burst_arbiter #(.DATA_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_req(w_req), .rx_kind(2'b00),
    .tx_req(1'b0), .tx_kind(2'b00), .rr_mode(1'b0), .tx_active(1'b0),
    .burst_code(6'd8), .rx_fifo_empty(1'b0), .tx_fifo_full(1'b0),
    .beat_ack(w_ack), .gnt_rx(g1_rx), .gnt_tx(g1_tx), .burst_beats(g1_beats),
    .burst_unbounded(g1_unb), .xfer_done(g1_done));

  dma_burst_arbiter #(.DATA_W(8)) u2 (
    .clk(clk), .rst_n(rst_n), .rx_req(w_req), .rx_kind(2'b00),
    .tx_req(1'b0), .tx_kind(2'b00), .rr_mode(1'b0), .tx_active(1'b0),
    .burst_code(6'd8), .rx_fifo_empty(1'b0), .tx_fifo_full(1'b0),
    .beat_ack(w_ack), .gnt_rx(g2_rx), .gnt_tx(g2_tx), .burst_beats(g2_beats),
    .burst_unbounded(g2_unb), .xfer_done(g2_done));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench model of data burst sizing: powers of two up to 32, zero, else 32
  function automatic int model_data_len(input int code);
    if (code == 0) return 0;
    if (code <= 32 && $countones(code) == 1) return code;
    return 32;
  endfunction

  // Monitor: compares each fresh grant against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt_rx && gnt_tx) check(0, "R12", "both grants high", 1, 0);
      if ((gnt_rx || gnt_tx) && !prev_gnt) begin
        if (q.size() == 0) begin
          check(0, "R5", "grant without expectation", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(gnt_rx == e.rx, e.tag, "winner is rx", int'(gnt_rx), int'(e.rx));
          check(int'(burst_beats) == e.beats, e.tag, "burst_beats", int'(burst_beats), e.beats);
          check(burst_unbounded == e.unb, e.tag, "burst_unbounded", int'(burst_unbounded), int'(e.unb));
        end
      end
      prev_gnt = gnt_rx || gnt_tx;
    end else begin
      prev_gnt = 0;
    end
  end

  task automatic do_reset();
    @(posedge clk) #1;
    rst_n = 0; rx_req = 0; tx_req = 0; beat_ack = 0; w_req = 0; w_ack = 0;
    rx_fifo_empty = 0; tx_fifo_full = 0;
    model_last_rx = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!gnt_rx && !gnt_tx, "R1", "grant after reset", int'(gnt_rx | gnt_tx), 0);
    check(!xfer_done, "R1", "done after reset", int'(xfer_done), 0);
  endtask

  // Driver: requests, pushes the expected grant, then runs the burst.
  task automatic burst(input bit rq_rx, input bit rq_tx, input logic [1:0] krx,
                       input logic [1:0] ktx, input logic [5:0] code,
                       input int unb_acks, input int stall, input bit keep,
                       input string tag);
    exp_t e;
    bit   win_rx;
    logic [1:0] wk;
    int   acks;
    bit   got;
    if (rq_rx && rq_tx)
      win_rx = (!rr_mode && !tx_active) ? 1'b1 : !model_last_rx;
    else
      win_rx = rq_rx;
    model_last_rx = win_rx;
    wk = win_rx ? krx : ktx;
    e.rx = win_rx;
    e.beats = (wk[1] == 1'b0) ? 1 : model_data_len(int'(code));
    e.unb = (wk[1] == 1'b1) && (e.beats == 0);
    e.tag = tag;
    q.push_back(e);
    acks = e.unb ? unb_acks : e.beats;

    @(posedge clk) #1;
    if (rq_rx) rx_req = 1;
    if (rq_tx) tx_req = 1;
    rx_kind = krx; tx_kind = ktx; burst_code = code;
    got = 0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (gnt_rx || gnt_tx) begin got = 1; break; end
    end
    check(got, tag, "grant arrived", int'(got), 1);
    for (int i = 0; i < acks; i++) begin
      if (i == 1) begin
        for (int s = 0; s < stall; s++) begin
          @(posedge clk) #1 beat_ack = 0;
          @(negedge clk);
          check((gnt_rx == win_rx) && (gnt_tx == !win_rx), "R10", "grant held in stall",
                int'(gnt_rx), int'(win_rx));
          check(!xfer_done, "R10", "no done in stall", int'(xfer_done), 0);
        end
      end
      @(posedge clk) #1;
      beat_ack = 1;
      if (e.unb) begin
        rx_fifo_empty = win_rx && (i == acks - 1);
        tx_fifo_full  = !win_rx && (i == acks - 1);
      end
      @(negedge clk);
      check(xfer_done == (i == acks - 1), e.unb ? "R8" : "R10", "done on beat",
            int'(xfer_done), int'(i == acks - 1));
    end
    @(posedge clk) #1;
    beat_ack = 0; rx_fifo_empty = 0; tx_fifo_full = 0;
    if (!keep) begin
      if (win_rx) rx_req = 0; else tx_req = 0;
    end
    @(negedge clk);
    check(!gnt_rx && !gnt_tx, "R11", "idle gap after done", int'(gnt_rx | gnt_tx), 0);
  endtask

  initial begin
    do_reset();
    rr_mode = 0; tx_active = 0;
    // R5 R6: lone receive descriptor fetch, 1 beat at width 32
    burst(1, 0, 2'b00, 2'b00, 6'd7, 0, 0, 0, "R6");
    // R7 R10: transmit data, code 4, stalled mid-burst
    burst(0, 1, 2'b00, 2'b10, 6'd4, 0, 2, 0, "R7");
    // R8: unbounded receive ends on rx_fifo_empty
    burst(1, 0, 2'b10, 2'b00, 6'd0, 5, 0, 0, "R8");
    // R8: unbounded transmit ends on tx_fifo_full
    burst(0, 1, 2'b00, 2'b11, 6'd0, 3, 0, 0, "R8");
    // R9: illegal codes
    burst(1, 0, 2'b10, 2'b00, 6'd5, 0, 0, 0, "R9");
    burst(0, 1, 2'b00, 2'b10, 6'd40, 0, 0, 0, "R9");
    // R7: remaining legal codes
    burst(1, 0, 2'b11, 2'b00, 6'd1, 0, 0, 0, "R7");
    burst(1, 0, 2'b10, 2'b00, 6'd2, 0, 0, 0, "R7");
    burst(0, 1, 2'b00, 2'b10, 6'd8, 0, 0, 0, "R7");
    burst(1, 0, 2'b10, 2'b00, 6'd16, 0, 0, 0, "R7");
    burst(0, 1, 2'b00, 2'b10, 6'd32, 0, 0, 0, "R7");
    // R3: receive-first, no transmission: rx twice, then pending tx
    burst(1, 1, 2'b01, 2'b01, 6'd0, 0, 0, 1, "R3");
    burst(1, 1, 2'b01, 2'b01, 6'd0, 0, 0, 0, "R3");
    burst(0, 1, 2'b01, 2'b01, 6'd0, 0, 0, 0, "R5");
    // R4: receive-first with transmission in progress interleaves
    tx_active = 1;
    burst(1, 1, 2'b01, 2'b01, 6'd0, 0, 0, 1, "R4");
    burst(1, 1, 2'b01, 2'b01, 6'd0, 0, 0, 1, "R4");
    burst(1, 1, 2'b01, 2'b01, 6'd0, 0, 0, 0, "R4");
    burst(!model_last_rx, model_last_rx, 2'b01, 2'b01, 6'd0, 0, 0, 0, "R4");
    tx_active = 0;
    // R2: round-robin, first tie after reset goes to receive
    do_reset();
    rr_mode = 1;
    burst(1, 1, 2'b00, 2'b00, 6'd0, 0, 0, 1, "R2");
    burst(1, 1, 2'b00, 2'b00, 6'd0, 0, 0, 1, "R2");
    burst(1, 1, 2'b00, 2'b00, 6'd0, 0, 0, 0, "R2");
    burst(!model_last_rx, model_last_rx, 2'b00, 2'b00, 6'd0, 0, 0, 0, "R2");

    // R6: descriptor sizing on 16-bit and 8-bit buses
    @(posedge clk) #1 w_req = 1;
    @(negedge clk);
    @(negedge clk);
    check(g1_rx && int'(g1_beats) == 2, "R6", "16-bit desc beats", int'(g1_beats), 2);
    check(g2_rx && int'(g2_beats) == 4, "R6", "8-bit desc beats", int'(g2_beats), 4);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk) #1 w_ack = 1; w_req = 0;
      @(negedge clk);
      if (i < 2) check(g1_done == (i == 1), "R6", "16-bit done beat", int'(g1_done), int'(i == 1));
      check(g2_done == (i == 3), "R6", "8-bit done beat", int'(g2_done), int'(i == 3));
    end
    @(posedge clk) #1 w_ack = 0;
    @(negedge clk);
    check(q.size() == 0, "R5", "all expected grants seen", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule